// File: doc/BRIEF.md
# Floating-Point Operand Classifier

The classifier takes one IEEE-754 operand, either single precision (32 bits) or double precision (64 bits), with a format select. One cycle after a valid strobe it returns a ten-bit one-hot class mask, zero-extended into a 64-bit result register. The mask tells apart the sign, infinity, normal, subnormal and zero cases, and it separates signaling NaNs from quiet NaNs. The block raises no exception flags. It performs no arithmetic, no conversion and no NaN propagation.

The same unit also registers the canonical default NaN for the selected format, next to the mask. Neighbouring datapaths that must produce a NaN can take that constant from here. A single-precision operand is read only from the low 32 bits of the operand bus, so a value that arrives with arbitrary upper bits classifies the same way.

Top module: `fclass_unit`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0, and `res_class` and `res_dnan` are all zeros.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` high, and 0 in the cycle after a cycle with `in_valid` low.
- R3: While `out_valid` is 1, exactly one bit of `res_class[9:0]` is set and `res_class[63:10]` is zero.
- R4: A negative non-NaN operand sets bit 0 for infinity, bit 1 for a normal value, bit 2 for a subnormal and bit 3 for zero.
- R5: A positive non-NaN operand sets bit 4 for zero, bit 5 for a subnormal, bit 6 for a normal value and bit 7 for infinity.
- R6: When the exponent field is all ones and the fraction is nonzero, bit 9 (quiet) is set if the top fraction bit is 1, and bit 8 (signaling) is set otherwise, whatever the sign.
- R7: When the exponent field is all zeros, a zero fraction gives the zero class and a nonzero fraction gives the subnormal class.
- R8: With `fmt_dbl` = 0 the fields are sign bit 31, exponent bits 30:23 and fraction bits 22:0, and bits 63:32 of the operand have no effect on the result. With `fmt_dbl` = 1 the fields are sign bit 63, exponent bits 62:52 and fraction bits 51:0.
- R9: With each valid result, `res_dnan` holds 0x000000007FC00000 if the captured format was single and 0x7FF8000000000000 if it was double.
- R10: In a cycle with `in_valid` low, `res_class` and `res_dnan` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand and format are valid this cycle |
| fmt_dbl | input | 1 | 1 = double precision, 0 = single precision |
| operand | input | 64 | Operand bits |
| out_valid | output | 1 | Result registers were loaded in the previous cycle |
| res_class | output | 64 | One-hot class mask in bits 9:0, upper bits zero |
| res_dnan | output | 64 | Default NaN for the captured format |

## Verification
Directed operands cover both signs of infinity, of the largest and smallest normal values, of subnormals and of zero, in both formats. They also include signaling and quiet NaNs with either sign, so each of the ten mask bits is hit and the quiet/signaling split is shown to ignore the sign. Single-precision operands are repeated with random upper 32 bits, which shows that the upper half is not read. Random operands whose exponents are biased toward all-zeros and all-ones are compared with a reference classifier in the bench. A stretch with valid held low confirms that the result and default-NaN registers hold their values.

// File: rtl/fcls_pkg.sv
package fcls_pkg;

  localparam int CLASS_W = 10;

  localparam int CLS_NEG_INF  = 0;
  localparam int CLS_NEG_NORM = 1;
  localparam int CLS_NEG_SUB  = 2;
  localparam int CLS_NEG_ZERO = 3;
  localparam int CLS_POS_ZERO = 4;
  localparam int CLS_POS_SUB  = 5;
  localparam int CLS_POS_NORM = 6;
  localparam int CLS_POS_INF  = 7;
  localparam int CLS_SNAN     = 8;
  localparam int CLS_QNAN     = 9;

  typedef struct packed {
    logic sgn;
    logic exp_ones;
    logic exp_zero;
    logic frac_zero;
    logic frac_msb;
  } fp_feat_t;

endpackage

// File: rtl/fcls_extract.sv
module fcls_extract
  import fcls_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int FMT_W = 1 + EXP_W + FRAC_W
) (
  input  logic [FMT_W-1:0] word,
  output fp_feat_t         feat
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = word[FMT_W-2:FRAC_W];
  assign frac_f = word[FRAC_W-1:0];

  always_comb begin
    feat.sgn       = word[FMT_W-1];
    feat.exp_ones  = &exp_f;
    feat.exp_zero  = ~|exp_f;
    feat.frac_zero = ~|frac_f;
    feat.frac_msb  = frac_f[FRAC_W-1];
  end

endmodule

// File: rtl/fcls_decode.sv
module fcls_decode
  import fcls_pkg::*;
(
  input  fp_feat_t             feat,
  output logic [CLASS_W-1:0]   mask
);

  always_comb begin
    mask = '0;
    if (feat.exp_ones) begin
      if (feat.frac_zero)
        mask[feat.sgn ? CLS_NEG_INF : CLS_POS_INF] = 1'b1;
      else if (feat.frac_msb)
        mask[CLS_QNAN] = 1'b1;
      else
        mask[CLS_SNAN] = 1'b1;
    end else if (feat.exp_zero) begin
      if (feat.frac_zero)
        mask[feat.sgn ? CLS_NEG_ZERO : CLS_POS_ZERO] = 1'b1;
      else
        mask[feat.sgn ? CLS_NEG_SUB : CLS_POS_SUB] = 1'b1;
    end else begin
      mask[feat.sgn ? CLS_NEG_NORM : CLS_POS_NORM] = 1'b1;
    end
  end

endmodule

// File: rtl/fcls_dnan.sv
module fcls_dnan #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int OUT_W  = 64,
  localparam int FMT_W = 1 + EXP_W + FRAC_W
) (
  output logic [OUT_W-1:0] nan_word
);

  logic [FMT_W-1:0] pattern;

  assign pattern  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  assign nan_word = OUT_W'(pattern);

endmodule

// File: rtl/fclass_unit.sv
module fclass_unit
  import fcls_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int SP_EXP_W  = 8,
  parameter int SP_FRAC_W = 23,
  parameter int DP_EXP_W  = 11,
  parameter int DP_FRAC_W = 52
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              fmt_dbl,
  input  logic [DATA_W-1:0] operand,
  output logic              out_valid,
  output logic [DATA_W-1:0] res_class,
  output logic [DATA_W-1:0] res_dnan
);

  localparam int NUM_FMT = 2;
  localparam int EXP_W_A[NUM_FMT]  = '{SP_EXP_W, DP_EXP_W};
  localparam int FRAC_W_A[NUM_FMT] = '{SP_FRAC_W, DP_FRAC_W};

  fp_feat_t          feat_a [NUM_FMT];
  logic [DATA_W-1:0] nan_a  [NUM_FMT];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int EW = EXP_W_A[g];
    localparam int FW = FRAC_W_A[g];
    localparam int TW = 1 + EW + FW;

    fcls_extract #(.EXP_W(EW), .FRAC_W(FW)) u_extract (
      .word (operand[TW-1:0]),
      .feat (feat_a[g])
    );

    fcls_dnan #(.EXP_W(EW), .FRAC_W(FW), .OUT_W(DATA_W)) u_dnan (
      .nan_word (nan_a[g])
    );
  end

  fp_feat_t           feat_sel;
  logic [CLASS_W-1:0] mask_c;

  assign feat_sel = fmt_dbl ? feat_a[1] : feat_a[0];

  fcls_decode u_decode (
    .feat (feat_sel),
    .mask (mask_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_class <= '0;
      res_dnan  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_class <= DATA_W'(mask_c);
        res_dnan  <= fmt_dbl ? nan_a[1] : nan_a[0];
      end
    end
  end

endmodule

// File: rtl/fcls_checks.sv
module fcls_checks #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              fmt_dbl,
  input logic [31:0]       op_lo,
  input logic              out_valid,
  input logic [DATA_W-1:0] res_class,
  input logic [DATA_W-1:0] res_dnan
);

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(res_class[9:0]) == 1 && res_class[DATA_W-1:10] == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_class) && $stable(res_dnan)));

  p_dnan_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> res_dnan == ($past(fmt_dbl) ? 64'h7FF8_0000_0000_0000
                                              : 64'h0000_0000_7FC0_0000));

  p_sp_nan_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(fmt_dbl) && $past(op_lo[30:23]) == 8'hFF && $past(op_lo[22:0]) != 23'd0)
    |-> (res_class[9:8] == {$past(op_lo[22]), !$past(op_lo[22])}));

  p_sp_sign_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(fmt_dbl) && $past(op_lo[30:23]) != 8'hFF)
    |-> ((|res_class[3:0]) == $past(op_lo[31])));

endmodule

bind fclass_unit fcls_checks #(.DATA_W(DATA_W)) u_fcls_checks (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .fmt_dbl   (fmt_dbl),
  .op_lo     (operand[31:0]),
  .out_valid (out_valid),
  .res_class (res_class),
  .res_dnan  (res_dnan)
);

// File: tb/sim_fclass_unit.sv
`timescale 1ns/1ps
module sim_fclass_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        fmt_dbl = 1'b0;
  logic [63:0] operand = '0;
  logic        out_valid;
  logic [63:0] res_class;
  logic [63:0] res_dnan;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fclass_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_dbl(fmt_dbl),
    .operand(operand), .out_valid(out_valid),
    .res_class(res_class), .res_dnan(res_dnan)
  );

  function automatic logic [63:0] ref_class(logic [63:0] op, logic dbl);
    logic s; logic eall1; logic eall0; logic fnz; logic fmsb; int idx;
    if (dbl) begin
      s = op[63]; eall1 = (op[62:52] == 11'h7FF); eall0 = (op[62:52] == 11'h0);
      fnz = (op[51:0] != 52'h0); fmsb = op[51];
    end else begin
      s = op[31]; eall1 = (op[30:23] == 8'hFF); eall0 = (op[30:23] == 8'h0);
      fnz = (op[22:0] != 23'h0); fmsb = op[22];
    end
    if (eall1 && fnz)      idx = fmsb ? 9 : 8;
    else if (eall1)        idx = s ? 0 : 7;
    else if (eall0 && fnz) idx = s ? 2 : 5;
    else if (eall0)        idx = s ? 3 : 4;
    else                   idx = s ? 1 : 6;
    return 64'd1 << idx;
  endfunction

  function automatic logic [63:0] ref_dnan(logic dbl);
    return dbl ? 64'h7FF8_0000_0000_0000 : 64'h0000_0000_7FC0_0000;
  endfunction

  function automatic string req_of(logic [63:0] m);
    if (m[9] || m[8]) return "R6";
    if (m[2] || m[3] || m[4] || m[5]) return "R7";
    if (m[3:0] != 0) return "R4";
    return "R5";
  endfunction

  task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (one register)
  task automatic classify(logic [63:0] op, logic dbl, string req);
    logic [63:0] exp_m;
    @(negedge clk);
    operand = op; fmt_dbl = dbl; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp_m = ref_class(op, dbl);
    check64("R2", "out_valid", {63'd0, out_valid}, 64'd1);
    check64(req, "class", res_class, exp_m);
    check64("R9", "dnan", res_dnan, ref_dnan(dbl));
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [63:0] held_c;
    logic [63:0] held_n;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check64("R1", "out_valid", {63'd0, out_valid}, 64'd0);
    check64("R1", "class", res_class, 64'd0);
    check64("R1", "dnan", res_dnan, 64'd0);

    // R4 / R5 directed, single
    classify(64'h0000_0000_FF80_0000, 1'b0, "R4");
    classify(64'h0000_0000_BF80_0000, 1'b0, "R4");
    classify(64'h0000_0000_8000_0001, 1'b0, "R7");
    classify(64'h0000_0000_8000_0000, 1'b0, "R7");
    classify(64'h0000_0000_0000_0000, 1'b0, "R7");
    classify(64'h0000_0000_007F_FFFF, 1'b0, "R7");
    classify(64'h0000_0000_0080_0000, 1'b0, "R5");
    classify(64'h0000_0000_7F80_0000, 1'b0, "R5");
    // R6 single, both signs
    classify(64'h0000_0000_7F80_0001, 1'b0, "R6");
    classify(64'h0000_0000_FFA0_0000, 1'b0, "R6");
    classify(64'h0000_0000_7FC0_0000, 1'b0, "R6");
    classify(64'h0000_0000_FFFF_FFFF, 1'b0, "R6");
    // R8: upper half ignored in single mode
    classify(64'hFFF0_0000_0000_0000, 1'b0, "R8");
    classify(64'h7FF8_1234_3F80_0000, 1'b0, "R8");
    classify(64'hDEAD_BEEF_0000_0001, 1'b0, "R8");
    // double format, R8 field positions
    classify(64'hFFF0_0000_0000_0000, 1'b1, "R4");
    classify(64'hC000_0000_0000_0000, 1'b1, "R4");
    classify(64'h8000_0000_0000_0001, 1'b1, "R7");
    classify(64'h8000_0000_0000_0000, 1'b1, "R7");
    classify(64'h0000_0000_0000_0000, 1'b1, "R7");
    classify(64'h000F_FFFF_FFFF_FFFF, 1'b1, "R7");
    classify(64'h0010_0000_0000_0000, 1'b1, "R5");
    classify(64'h7FF0_0000_0000_0000, 1'b1, "R5");
    classify(64'h0000_0000_7F80_0000, 1'b1, "R8");
    classify(64'h7FF0_0000_0000_0001, 1'b1, "R6");
    classify(64'hFFF4_0000_0000_0000, 1'b1, "R6");
    classify(64'h7FF8_0000_0000_0000, 1'b1, "R6");
    classify(64'hFFF8_0000_0000_0000, 1'b1, "R6");

    // R10: hold while in_valid low, with changing inputs; R2 valid low
    held_c = res_class; held_n = res_dnan;
    @(negedge clk); operand = 64'h0; fmt_dbl = ~fmt_dbl;
    @(negedge clk); operand = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    check64("R10", "class hold", res_class, held_c);
    check64("R10", "dnan hold", res_dnan, held_n);
    check64("R2", "out_valid low", {63'd0, out_valid}, 64'd0);

    // random with biased exponents, R3 one-hot over all
    for (int i = 0; i < 400; i++) begin
      logic [63:0] op; logic dbl; logic [63:0] em; int pick;
      op = {$urandom, $urandom};
      dbl = $urandom_range(0, 1);
      pick = $urandom_range(0, 3);
      if (dbl) begin
        if (pick == 0) op[62:52] = 11'h7FF;
        if (pick == 1) op[62:52] = 11'h0;
      end else begin
        if (pick == 0) op[30:23] = 8'hFF;
        if (pick == 1) op[30:23] = 8'h0;
      end
      if ($urandom_range(0, 5) == 0) begin
        if (dbl) op[51:0] = '0; else op[22:0] = '0;
      end
      em = ref_class(op, dbl);
      classify(op, dbl, req_of(em));
      check64("R3", "onehot count", 64'($countones(res_class)), 64'd1);
    end

    // R1 again: reset mid-run clears registers
    @(negedge clk); in_valid = 1'b1; rst = 1'b1;
    @(negedge clk); in_valid = 1'b0; rst = 1'b0;
    check64("R1", "class after reset", res_class, 64'd0);
    check64("R1", "out_valid after reset", {63'd0, out_valid}, 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule